// File: doc/BRIEF.md
# Multiply-Accumulate Saturation Back End

This block sits behind the multiplier array of a multiply-accumulate unit. It takes a raw 64-bit product, or an addend already conditioned, and does the arithmetic that follows. It can condition a product for integer signed, integer unsigned or fractional arithmetic. It can add a value into one of four accumulators, saturate the sum and raise status flags. It can also read an accumulator out as a 32-bit or 16-bit value, with optional rounding and clamping. The accumulators hold 48 significant bits in 64-bit storage.

Four mode bits in a status register select the arithmetic: fractional versus integer, signed versus unsigned, rounding, and saturate-on-overflow. The same register collects the result flags and one sticky overflow bit per accumulator. The block accepts one request per clock: an opcode, an accumulator index and a 64-bit data word. The response is registered and appears with a valid strobe on the following cycle.

Top module: `mac_sat_unit`

## Requirements
- R1: After a synchronous reset, rsp_valid is 0, status_q is 0 and every accumulator reads as 0.
- R2: Each request raises rsp_valid for exactly the next cycle, and rsp_valid is 0 after an idle cycle. Opcodes are COND=0, MACC=1, READ=2, LOAD=3 and WRSR=4. Any other opcode returns rsp_data 0 and changes neither the status nor the accumulators.
- R3: The status_q bit positions are as follows. Bit 0 is EV, bit 1 is V, bit 2 is Z, bit 3 is N, bit 4 is round, bit 5 is fractional, bit 6 is signed and bit 7 is saturate. Bits 8+i are the sticky overflow bits of accumulator i. WRSR loads status_q from req_data and echoes the loaded value. No other operation clears a status bit or changes a mode bit. The arithmetic is fractional when bit 5 is set, signed when only bit 6 is set, and unsigned otherwise.
- R4: COND in signed mode returns the product if it equals its sign extension from bit 39. Otherwise it sets V and returns either that sign extension or, in saturate mode, 2^50 for a non-negative product and the bitwise complement of 2^50 for a negative one.
- R5: COND in unsigned mode sets V when any of bits 63..40 is set. It then returns 2^50 in saturate mode, or the product truncated to 40 bits otherwise. A product that fits is returned unchanged.
- R6: COND in fractional mode returns the product shifted right by 24. With round set, a 24-bit remainder above 0x800000 adds one, and a remainder of exactly 0x800000 adds the shifted value's LSB. V is not changed.
- R7: MACC in signed mode adds req_data to the indexed accumulator. It sets V when the sum does not equal its sign extension from bit 47. If V is then set, whether newly or from before, the accumulator's sticky bit is set. In that case saturate mode writes 0x7FFFFFFF or its 64-bit negative counterpart, chosen by bit 47 of the sum; otherwise the sum is sign-extended from bit 47.
- R8: MACC in unsigned mode sets V when bits 63..48 of the sum are nonzero, and then sets the sticky bit. When V is set, saturate mode writes 0 if the sum exceeds 2^53 and 2^48-1 otherwise. Without saturate mode the sum is truncated to 48 bits.
- R9: MACC in fractional mode applies the 48-bit signed fit test of R7 and, when V is set with saturate mode, clamps to 2^47-1 or its 64-bit complement.
- R10: After MACC the written value W sets flags. Z is set if W is 0; otherwise N is set if W[47] is 1. V is set if the accumulator's sticky bit is set. EV is set when bits 63..40 (fractional) or bits 63..32 (signed) are not all equal, or, in unsigned mode, when any bit of 63..32 is nonzero. Flags are only ever OR-ed in.
- R11: READ in fractional mode with the signed bit set returns bits 39..24 of the accumulator, rounded ties-to-even on the 24-bit remainder regardless of the round bit. With saturate mode, a rounding carry out of 16 bits returns 0x7FFF.
- R12: READ in fractional 32-bit mode arithmetically shifts the accumulator right by 8, rounding ties-to-even on the 8-bit remainder when round is set. With saturate mode, a value that does not fit in 32 signed bits returns 0x7FFFFFFF or 0x80000000 by sign; otherwise it returns the low 32 bits.
- R13: READ in signed integer mode returns the low 32 bits if the accumulator fits in 32 signed bits, else 0x7FFFFFFF or 0x80000000 by sign. In unsigned mode it returns 0xFFFFFFFF if any bit above 31 is set. Readouts are zero-extended into rsp_data.
- R14: LOAD writes req_data into the indexed accumulator, echoes it on rsp_data, and leaves status_q unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_idx | input | 2 | Accumulator index |
| req_data | input | 64 | Product, addend, load value or status word |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_data | output | 64 | Registered result |
| status_q | output | 12 | Mode bits, flags and sticky overflow bits |

## Verification
A corrupted accumulator stays hidden until the next READ or MACC of that index returns a wrong word, so the directed tests load, add and read back within a few cycles. Errors in the status register are visible at once on status_q, the cycle after the operation. The tests therefore compare the full status word after every accumulate, so a flag set late, set in the wrong position or lost shows up straight away. The rounding ties, the unsigned clamp above 2^53 and the clamping by a V flag left over from an earlier operation each get a dedicated case. These are the points where a small slip in the datapath changes only a few results.

// File: rtl/macsat_pkg.sv
package macsat_pkg;
  localparam int ST_EV   = 0;
  localparam int ST_V    = 1;
  localparam int ST_Z    = 2;
  localparam int ST_N    = 3;
  localparam int ST_RND  = 4;
  localparam int ST_FRAC = 5;
  localparam int ST_SGN  = 6;
  localparam int ST_SATM = 7;
  localparam int ST_STK  = 8;

  typedef enum logic [2:0] {
    OP_COND = 3'd0,
    OP_MACC = 3'd1,
    OP_READ = 3'd2,
    OP_LOAD = 3'd3,
    OP_WRSR = 3'd4
  } mac_op_e;

  // field order matches status bits 7..4
  typedef struct packed {
    logic satm;
    logic sgn;
    logic frac;
    logic rnd;
  } mode_t;

  typedef enum logic [1:0] {K_UNS, K_SGN, K_FRC} arith_e;

  function automatic arith_e kind_of(input mode_t m);
    if (m.frac)     return K_FRC;
    else if (m.sgn) return K_SGN;
    else            return K_UNS;
  endfunction
endpackage

// File: rtl/macsat_prod_cond.sv
module macsat_prod_cond
  import macsat_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int KEEP_W  = 40,
  parameter int FRAC_SH = 24,
  parameter int BIG_EXP = 50
) (
  input  logic [WORD_W-1:0] prod,
  input  mode_t             mode,
  output logic [WORD_W-1:0] res,
  output logic              ovf
);
  localparam logic [WORD_W-1:0]  BIG  = WORD_W'(1) << BIG_EXP;
  localparam logic [FRAC_SH-1:0] HALF = {1'b1, {(FRAC_SH-1){1'b0}}};

  logic [WORD_W-1:0]  sext_k, trunc_k, shifted;
  logic [FRAC_SH-1:0] rem;
  logic               up;

  always_comb begin
    sext_k  = {{(WORD_W-KEEP_W){prod[KEEP_W-1]}}, prod[KEEP_W-1:0]};
    trunc_k = {{(WORD_W-KEEP_W){1'b0}}, prod[KEEP_W-1:0]};
    shifted = prod >> FRAC_SH;
    rem     = prod[FRAC_SH-1:0];
    up      = mode.rnd && ((rem > HALF) || ((rem == HALF) && shifted[0]));
    res     = prod;
    ovf     = 1'b0;
    unique case (kind_of(mode))
      K_SGN: begin
        ovf = (sext_k != prod);
        if (ovf && mode.satm) res = prod[WORD_W-1] ? ~BIG : BIG;
        else                  res = sext_k;
      end
      K_UNS: begin
        ovf = |prod[WORD_W-1:KEEP_W];
        if (ovf) res = mode.satm ? BIG : trunc_k;
      end
      default: res = shifted + WORD_W'(up);
    endcase
  end
endmodule

// File: rtl/macsat_acc_sat.sv
module macsat_acc_sat #(
  parameter int WORD_W  = 64,
  parameter int ACC_W   = 48,
  parameter int EXT_FRC = 40,
  parameter int EXT_INT = 32,
  parameter int ULIM_EX = 53
) (
  input  logic [WORD_W-1:0] acc_old,
  input  logic [WORD_W-1:0] addend,
  input  logic              frac,
  input  logic              sgn,
  input  logic              satm,
  input  logic              v_prev,
  input  logic              stk_prev,
  output logic [WORD_W-1:0] acc_new,
  output logic              stk_set,
  output logic [3:0]        flg     // {N, Z, V, EV}
);
  localparam logic [WORD_W-1:0] POS_I = (WORD_W'(1) << (EXT_INT-1)) - WORD_W'(1);
  localparam logic [WORD_W-1:0] POS_F = (WORD_W'(1) << (ACC_W-1)) - WORD_W'(1);
  localparam logic [WORD_W-1:0] U_MAX = (WORD_W'(1) << ACC_W) - WORD_W'(1);
  localparam logic [WORD_W-1:0] U_LIM = WORD_W'(1) << ULIM_EX;

  logic [WORD_W-1:0] sum, s_fit, u_cut;
  logic ovf, vnow, z, n, ev;

  always_comb begin
    sum   = acc_old + addend;
    s_fit = {{(WORD_W-ACC_W){sum[ACC_W-1]}}, sum[ACC_W-1:0]};
    u_cut = {{(WORD_W-ACC_W){1'b0}}, sum[ACC_W-1:0]};
    ovf   = (frac || sgn) ? (s_fit != sum) : (|sum[WORD_W-1:ACC_W]);
    vnow  = v_prev || ovf;
    if (frac) begin
      acc_new = (vnow && satm) ? (s_fit[WORD_W-1] ? ~POS_F : POS_F) : s_fit;
    end else if (sgn) begin
      acc_new = (vnow && satm) ? (s_fit[WORD_W-1] ? ~POS_I : POS_I) : s_fit;
    end else if (vnow) begin
      acc_new = satm ? ((sum > U_LIM) ? '0 : U_MAX) : u_cut;
    end else begin
      acc_new = sum;
    end
    z = (acc_new == '0);
    n = !z && acc_new[ACC_W-1];
    if (frac)
      ev = !((&acc_new[WORD_W-1:EXT_FRC]) || !(|acc_new[WORD_W-1:EXT_FRC]));
    else if (sgn)
      ev = !((&acc_new[WORD_W-1:EXT_INT]) || !(|acc_new[WORD_W-1:EXT_INT]));
    else
      ev = |acc_new[WORD_W-1:EXT_INT];
    stk_set = vnow;
    flg     = {n, z, stk_prev || vnow, ev};
  end
endmodule

// File: rtl/macsat_readout.sv
module macsat_readout
  import macsat_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int OUT_W  = 32,
  parameter int HALF_W = 16,
  parameter int H_SH   = 24,
  parameter int F_SH   = 8
) (
  input  logic [WORD_W-1:0] acc,
  input  mode_t             mode,
  output logic [OUT_W-1:0]  rd
);
  localparam logic [H_SH-1:0]  HALF_H = {1'b1, {(H_SH-1){1'b0}}};
  localparam logic [F_SH-1:0]  HALF_F = {1'b1, {(F_SH-1){1'b0}}};
  localparam logic [OUT_W-1:0] MAXV   = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MINV   = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] H_POS  = OUT_W'((1 << (HALF_W-1)) - 1);

  logic [H_SH-1:0]   rem_h;
  logic [F_SH-1:0]   rem_f;
  logic [HALF_W:0]   h_val;
  logic [WORD_W-1:0] f_sh, f_val;
  logic up_h, up_f, f_fit, i_fit;

  always_comb begin
    rem_h = acc[H_SH-1:0];
    up_h  = (rem_h > HALF_H) || ((rem_h == HALF_H) && acc[H_SH]);
    h_val = {1'b0, acc[H_SH+HALF_W-1:H_SH]} + (HALF_W+1)'(up_h);
    rem_f = acc[F_SH-1:0];
    f_sh  = WORD_W'($signed(acc) >>> F_SH);
    up_f  = mode.rnd && ((rem_f > HALF_F) || ((rem_f == HALF_F) && f_sh[0]));
    f_val = f_sh + WORD_W'(up_f);
    f_fit = (&f_val[WORD_W-1:OUT_W-1]) || !(|f_val[WORD_W-1:OUT_W-1]);
    i_fit = (&acc[WORD_W-1:OUT_W-1]) || !(|acc[WORD_W-1:OUT_W-1]);
    if (mode.frac) begin
      if (mode.sgn)
        rd = (mode.satm && h_val[HALF_W]) ? H_POS : OUT_W'(h_val[HALF_W-1:0]);
      else
        rd = (mode.satm && !f_fit) ? (f_val[WORD_W-1] ? MINV : MAXV) : f_val[OUT_W-1:0];
    end else if (mode.sgn) begin
      rd = i_fit ? acc[OUT_W-1:0] : (acc[WORD_W-1] ? MINV : MAXV);
    end else begin
      rd = (|acc[WORD_W-1:OUT_W]) ? '1 : acc[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import macsat_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int WORD_W  = 64,
  parameter int ACC_W   = 48,
  parameter int OUT_W   = 32
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  req_valid,
  input  logic [2:0]                            req_op,
  input  logic [((NUM_ACC>1)?$clog2(NUM_ACC):1)-1:0] req_idx,
  input  logic [WORD_W-1:0]                     req_data,
  output logic                                  rsp_valid,
  output logic [WORD_W-1:0]                     rsp_data,
  output logic [ST_STK+NUM_ACC-1:0]             status_q
);
  localparam int IDX_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1;
  localparam int ST_W  = ST_STK + NUM_ACC;

  logic [WORD_W-1:0] acc_q [NUM_ACC];
  logic [WORD_W-1:0] acc_rd, cond_res, sat_new, rsp_nxt, acc_wd;
  logic [OUT_W-1:0]  rd_word;
  logic [ST_W-1:0]   st_nxt;
  logic [3:0]        sat_flg;
  logic              cond_ovf, stk_set, acc_we;
  mode_t             mode;
  logic [IDX_W-1:0]  unused_idx;

  assign mode       = mode_t'(status_q[ST_SATM:ST_RND]);
  assign acc_rd     = acc_q[req_idx];
  assign unused_idx = req_idx;

  macsat_prod_cond #(.WORD_W(WORD_W)) u_cond (
    .prod(req_data), .mode(mode), .res(cond_res), .ovf(cond_ovf));

  macsat_acc_sat #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_sat (
    .acc_old(acc_rd), .addend(req_data),
    .frac(mode.frac), .sgn(mode.sgn), .satm(mode.satm),
    .v_prev(status_q[ST_V]), .stk_prev(status_q[ST_STK + int'(req_idx)]),
    .acc_new(sat_new), .stk_set(stk_set), .flg(sat_flg));

  macsat_readout #(.WORD_W(WORD_W), .OUT_W(OUT_W)) u_rd (
    .acc(acc_rd), .mode(mode), .rd(rd_word));

  always_comb begin
    st_nxt  = status_q;
    rsp_nxt = '0;
    acc_we  = 1'b0;
    acc_wd  = req_data;
    case (mac_op_e'(req_op))
      OP_COND: begin
        rsp_nxt       = cond_res;
        st_nxt[ST_V]  = status_q[ST_V] | cond_ovf;
      end
      OP_MACC: begin
        rsp_nxt     = sat_new;
        acc_we      = 1'b1;
        acc_wd      = sat_new;
        st_nxt[3:0] = status_q[3:0] | sat_flg;
        st_nxt[ST_STK + int'(req_idx)] = status_q[ST_STK + int'(req_idx)] | stk_set;
      end
      OP_READ: rsp_nxt = WORD_W'(rd_word);
      OP_LOAD: begin
        rsp_nxt = req_data;
        acc_we  = 1'b1;
      end
      OP_WRSR: begin
        st_nxt  = req_data[ST_W-1:0];
        rsp_nxt = WORD_W'(req_data[ST_W-1:0]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      status_q  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_data <= rsp_nxt;
        status_q <= st_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ACC; i++) acc_q[i] <= '0;
    end else if (req_valid && acc_we) begin
      acc_q[req_idx] <= acc_wd;
    end
  end
endmodule

// File: rtl/macsat_checker.sv
module macsat_checker
  import macsat_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int WORD_W  = 64,
  parameter int IDX_W   = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic [2:0]                req_op,
  input logic [IDX_W-1:0]          req_idx,
  input logic                      rsp_valid,
  input logic [WORD_W-1:0]         rsp_data,
  input logic [ST_STK+NUM_ACC-1:0] status_q
);
  logic is_wrsr, is_read, is_macc;
  assign is_wrsr = req_valid && (req_op == OP_WRSR);
  assign is_read = req_valid && (req_op == OP_READ);
  assign is_macc = req_valid && (req_op == OP_MACC);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst) !is_wrsr |=> $stable(status_q[ST_SATM:ST_RND])); // R3
  AST_FLAGS_ONLY_RISE: assert property (@(posedge clk) disable iff (rst) !is_wrsr |=> ((status_q & $past(status_q)) == $past(status_q))); // R10
  AST_STICKY_GIVES_V: assert property (@(posedge clk) disable iff (rst) is_macc |=> (!status_q[ST_STK + int'($past(req_idx))] || status_q[ST_V])); // R10
  AST_HALF_READ_WIDTH: assert property (@(posedge clk) disable iff (rst) (is_read && status_q[ST_FRAC] && status_q[ST_SGN]) |=> (rsp_data[WORD_W-1:16] == '0)); // R11
  AST_READ_WIDTH: assert property (@(posedge clk) disable iff (rst) is_read |=> (rsp_data[WORD_W-1:32] == '0)); // R13
endmodule

bind mac_sat_unit macsat_checker #(.NUM_ACC(NUM_ACC), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .status_q(status_q));

// File: tb/test_mac_sat_unit.sv
module test_mac_sat_unit;
  import macsat_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1, req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_idx = '0;
  logic [63:0] req_data = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic [11:0] status_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic last_vld;

  mac_sat_unit i_mac_sat_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .status_q(status_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input logic [2:0] code, input int idx, input logic [63:0] d,
                    output logic [63:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_op = code; req_idx = 2'(idx); req_data = d;
    @(negedge clk);
    r = rsp_data; last_vld = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic wsr(input logic [11:0] m);
    logic [63:0] r;
    op(OP_WRSR, 0, 64'(m), r);
  endtask

  task automatic ld(input int idx, input logic [63:0] v);
    logic [63:0] r;
    op(OP_LOAD, idx, v, r);
  endtask

  task automatic chk_op(input string tag, input logic [2:0] code, input int idx,
                        input logic [63:0] d, input logic [63:0] exp);
    logic [63:0] r;
    op(code, idx, d, r);
    chk(tag, r, exp);
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 status", 64'(status_q), 64'd0);
    chk_op("R1 acc2 read", OP_READ, 2, 64'd0, 64'd0);
  endtask

  task automatic t_handshake();
    logic [63:0] r;
    op(OP_READ, 0, 64'd0, r);
    chk("R2 valid after request", 64'(last_vld), 64'd1);
    @(negedge clk);
    chk("R2 valid idle", 64'(rsp_valid), 64'd0);
    ld(1, 64'h55);
    wsr(12'h040);
    chk_op("R2 unknown opcode data", 3'd7, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    chk("R2 unknown opcode status", 64'(status_q), 64'h040);
    wsr(12'h000);
    chk_op("R2 unknown opcode acc", OP_READ, 1, 64'd0, 64'h55);
  endtask

  task automatic t_wrsr();
    chk_op("R3 wrsr echo", OP_WRSR, 0, 64'h0000_0000_0000_0FF3, 64'hFF3);
    chk("R3 wrsr status", 64'(status_q), 64'hFF3);
    wsr(12'h000);
    chk("R3 wrsr clears", 64'(status_q), 64'h000);
  endtask

  task automatic t_prod_signed();
    wsr(12'h040);
    chk_op("R4 fits", OP_COND, 0, 64'h0000_0012_3456_7890, 64'h0000_0012_3456_7890);
    chk("R4 fits no V", 64'(status_q), 64'h040);
    chk_op("R4 wrap", OP_COND, 0, 64'h0000_0080_0000_0000, 64'hFFFF_FF80_0000_0000);
    chk("R4 wrap V", 64'(status_q), 64'h042);
    wsr(12'h0C0);
    chk_op("R4 sat pos", OP_COND, 0, 64'h0000_0100_0000_0000, 64'h0004_0000_0000_0000);
    chk_op("R4 sat neg", OP_COND, 0, 64'hFFFF_F000_0000_0000, 64'hFFFB_FFFF_FFFF_FFFF);
    chk("R4 sat V", 64'(status_q), 64'h0C2);
  endtask

  task automatic t_prod_unsigned();
    wsr(12'h000);
    chk_op("R5 truncate", OP_COND, 0, 64'h0000_0123_4567_89AB, 64'h0000_0023_4567_89AB);
    chk("R5 truncate V", 64'(status_q), 64'h002);
    wsr(12'h080);
    chk_op("R5 fits", OP_COND, 0, 64'h0000_00FF_FFFF_FFFF, 64'h0000_00FF_FFFF_FFFF);
    chk("R5 fits no V", 64'(status_q), 64'h080);
    chk_op("R5 sat", OP_COND, 0, 64'h0000_0123_4567_89AB, 64'h0004_0000_0000_0000);
    chk("R5 sat V", 64'(status_q), 64'h082);
  endtask

  task automatic t_prod_frac();
    wsr(12'h030);
    chk_op("R6 tie odd", OP_COND, 0, 64'h0180_0000, 64'd2);
    chk_op("R6 tie even", OP_COND, 0, 64'h0280_0000, 64'd2);
    chk_op("R6 above half", OP_COND, 0, 64'h0280_0001, 64'd3);
    chk_op("R6 max rem", OP_COND, 0, 64'h02FF_FFFF, 64'd3);
    wsr(12'h020);
    chk_op("R6 no round", OP_COND, 0, 64'h0180_0000, 64'd1);
    chk("R6 no V", 64'(status_q), 64'h020);
  endtask

  task automatic t_acc_signed();
    wsr(12'h040);
    ld(1, 64'h0000_7FFF_FFFF_FFF0);
    chk_op("R7 wrap", OP_MACC, 1, 64'h20, 64'hFFFF_8000_0000_0010);
    chk("R7 wrap status", 64'(status_q), 64'h24B);
    wsr(12'h0C0);
    ld(1, 64'h0000_7FFF_FFFF_FFF0);
    chk_op("R7 clamp neg", OP_MACC, 1, 64'h20, 64'hFFFF_FFFF_8000_0000);
    chk("R7 clamp status", 64'(status_q), 64'h2CA);
    ld(2, 64'd5);
    chk_op("R7 prior V clamps", OP_MACC, 2, 64'd1, 64'h0000_0000_7FFF_FFFF);
    chk("R7 prior V sticky", 64'(status_q), 64'h6CA);
  endtask

  task automatic t_acc_unsigned();
    wsr(12'h080);
    ld(3, 64'h0000_FFFF_FFFF_FFFF);
    chk_op("R8 clamp max", OP_MACC, 3, 64'd1, 64'h0000_FFFF_FFFF_FFFF);
    chk("R8 clamp status", 64'(status_q), 64'h88B);
    ld(3, 64'h0040_0000_0000_0000);
    chk_op("R8 above 2^53", OP_MACC, 3, 64'd0, 64'd0);
    chk("R8 zero status", 64'(status_q), 64'h88F);
    wsr(12'h000);
    ld(3, 64'h0001_0000_0000_0005);
    chk_op("R8 truncate", OP_MACC, 3, 64'd0, 64'd5);
    chk("R8 truncate status", 64'(status_q), 64'h802);
  endtask

  task automatic t_acc_frac();
    wsr(12'h0A0);
    ld(0, 64'h0000_7FFF_FFFF_FFFF);
    chk_op("R9 clamp", OP_MACC, 0, 64'd1, 64'hFFFF_8000_0000_0000);
    chk("R9 clamp status", 64'(status_q), 64'h1AB);
    wsr(12'h020);
    ld(1, 64'h0000_7FFF_FFFF_FFFF);
    chk_op("R9 wrap", OP_MACC, 1, 64'd2, 64'hFFFF_8000_0000_0001);
    chk("R9 wrap status", 64'(status_q), 64'h22B);
  endtask

  task automatic t_flags();
    wsr(12'h000);
    ld(0, 64'd0);
    chk_op("R10 zero", OP_MACC, 0, 64'd0, 64'd0);
    chk("R10 Z only", 64'(status_q), 64'h004);
    wsr(12'h000);
    ld(1, 64'h0000_8000_0000_0000);
    chk_op("R10 unsigned N", OP_MACC, 1, 64'd0, 64'h0000_8000_0000_0000);
    chk("R10 N and EV", 64'(status_q), 64'h009);
    wsr(12'h040);
    ld(0, 64'h0000_0001_0000_0000);
    chk_op("R10 signed ext", OP_MACC, 0, 64'd0, 64'h0000_0001_0000_0000);
    chk("R10 EV only", 64'(status_q), 64'h041);
    wsr(12'h140);
    ld(0, 64'd7);
    chk_op("R10 sticky V", OP_MACC, 0, 64'd1, 64'd8);
    chk("R10 V from sticky", 64'(status_q), 64'h142);
  endtask

  task automatic t_read_half();
    wsr(12'h060);
    ld(0, 64'h0000_0012_3480_0000);
    chk_op("R11 tie even", OP_READ, 0, 64'd0, 64'h1234);
    ld(0, 64'h0000_0012_3580_0000);
    chk_op("R11 tie odd", OP_READ, 0, 64'd0, 64'h1236);
    ld(0, 64'h0000_00FF_FFFF_FFFF);
    chk_op("R11 carry wrap", OP_READ, 0, 64'd0, 64'h0000);
    wsr(12'h0E0);
    chk_op("R11 carry clamp", OP_READ, 0, 64'd0, 64'h7FFF);
  endtask

  task automatic t_read_frac32();
    wsr(12'h030);
    ld(0, 64'h180);
    chk_op("R12 tie odd", OP_READ, 0, 64'd0, 64'd2);
    ld(0, 64'h280);
    chk_op("R12 tie even", OP_READ, 0, 64'd0, 64'd2);
    ld(0, 64'h181);
    chk_op("R12 above half", OP_READ, 0, 64'd0, 64'd2);
    ld(0, 64'h17F);
    chk_op("R12 below half", OP_READ, 0, 64'd0, 64'd1);
    ld(0, 64'h0000_7F00_0000_0000);
    chk_op("R12 no sat wrap", OP_READ, 0, 64'd0, 64'd0);
    wsr(12'h020);
    ld(0, 64'h1FF);
    chk_op("R12 no round", OP_READ, 0, 64'd0, 64'd1);
    wsr(12'h0B0);
    ld(0, 64'h0000_7F00_0000_0000);
    chk_op("R12 sat pos", OP_READ, 0, 64'd0, 64'h7FFF_FFFF);
    ld(0, 64'hFFFF_8000_0000_0000);
    chk_op("R12 sat neg", OP_READ, 0, 64'd0, 64'h8000_0000);
    ld(0, 64'hFFFF_FFFF_FFFF_FF00);
    chk_op("R12 small neg", OP_READ, 0, 64'd0, 64'hFFFF_FFFF);
  endtask

  task automatic t_read_int();
    wsr(12'h040);
    ld(2, 64'hFFFF_FFFF_FFFF_FFFE);
    chk_op("R13 signed fits", OP_READ, 2, 64'd0, 64'hFFFF_FFFE);
    ld(2, 64'h0000_0001_0000_0000);
    chk_op("R13 signed pos", OP_READ, 2, 64'd0, 64'h7FFF_FFFF);
    ld(2, 64'hFFFF_FFFE_0000_0000);
    chk_op("R13 signed neg", OP_READ, 2, 64'd0, 64'h8000_0000);
    wsr(12'h000);
    ld(2, 64'h0000_0001_0000_0000);
    chk_op("R13 unsigned sat", OP_READ, 2, 64'd0, 64'hFFFF_FFFF);
    ld(2, 64'h1234);
    chk_op("R13 unsigned fits", OP_READ, 2, 64'd0, 64'h1234);
  endtask

  task automatic t_load();
    wsr(12'h000);
    chk_op("R14 echo", OP_LOAD, 3, 64'hDEAD_BEEF, 64'hDEAD_BEEF);
    chk("R14 status kept", 64'(status_q), 64'h000);
    chk_op("R14 readback", OP_READ, 3, 64'd0, 64'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_handshake();
    t_wrsr();
    t_prod_signed();
    t_prod_unsigned();
    t_prod_frac();
    t_acc_signed();
    t_acc_unsigned();
    t_acc_frac();
    t_flags();
    t_read_half();
    t_read_frac32();
    t_read_int();
    t_load();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule